// File: doc/BRIEF.md
# Self-Calibrating Serial Byte Receiver

This block receives asynchronous serial bytes framed as one start bit, eight data bits and one stop bit, with no parity. It runs from one fixed clock that is nominally 307200 Hz. It has no rate-select input. Instead, it times the low period of the first start bit it sees after reset and picks one of five line rates from that width: 19200, 9600, 4800, 2400 or 1200 baud.

The serial input passes through a two-flop synchroniser before any logic uses it. At the first synchronised falling edge, a width counter starts. When the line rises, the width is matched against a tolerance window of plus or minus 25 percent around each rate's bit time. A match locks the rate until reset. A miss returns the receiver to idle.

Once the rate is locked, a divider produces sixteen ticks per bit. Each data bit is sampled near its centre and shifted in least significant bit first. The stop bit is then checked. A byte with a good stop bit is presented on the output together with a one-clock strobe. The frame used for calibration must carry a 1 in data bit 0, so that the rising edge marks the end of the start bit. Its byte is also delivered.

Top module: `autobaud_rx`

## Requirements
- R1: While reset is applied and right after it is released, `rx_valid`, `baud_ok`, `baud_sel` and `rx_byte` are all zero.
- R2: Before a rate is locked, the first synchronised low pulse of width w clock cycles locks rate index k exactly when 3·B ≤ 4·w ≤ 5·B, where B = 16·2^k. The encoding is k=0 for 19200 baud (16 cycles per bit), 1 for 9600, 2 for 4800, 3 for 2400 and 4 for 1200 baud (256 cycles per bit). On a lock, `baud_ok` goes high and `baud_sel` shows k.
- R3: A first low pulse outside every window is discarded, including any pulse longer than 320 cycles. `baud_ok` stays low and no byte is delivered.
- R4: Once `baud_ok` is high, it and `baud_sel` hold their values until reset, whatever later traffic arrives at any width.
- R5: The calibration frame's byte is delivered. Its data bits are timed from the rising edge that ends its start bit, with bit 0 sampled half a bit period after that edge. Bit 0 of the calibration byte must be 1.
- R6: After lock, the block divides the clock by 2^k to give sixteen ticks per bit. Data bit j is sampled 24+16·j ticks after the synchronised falling edge of the start bit, and bits are assembled least significant bit first into `rx_byte`.
- R7: Each accepted frame raises `rx_valid` for exactly one clock. `rx_byte` changes only in a cycle where `rx_valid` is high.
- R8: A frame whose stop bit samples low is dropped. `rx_valid` stays low and `rx_byte` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock, nominally 307200 Hz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_byte | output | 8 | Last accepted byte |
| rx_valid | output | 1 | One-clock strobe when a new byte is accepted |
| baud_ok | output | 1 | High once a line rate has been locked |
| baud_sel | output | 3 | Locked rate index (0 = 19200 baud ... 4 = 1200 baud) |

## Verification
The bench builds the block with its default parameters: sixteen ticks per bit, five rates and eight data bits. With these values the fastest bit lasts sixteen cycles and the slowest 256. A frame at the fastest rate is short enough to sweep all 256 byte values after locking at that rate. For every rate, the calibration pulse is driven at the two window edges, just outside each edge, and at the nominal width. A single-cycle glitch and an over-long pulse are also tried. Every rate is then checked for mixed byte patterns, a dropped frame with a low stop bit, and lock retention under traffic at a different rate.

// File: rtl/ab_pkg.sv
`timescale 1ns/1ps
package ab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_DATA = 2'd2
  } ab_state_t;
endpackage

// File: rtl/ab_sync.sv
`timescale 1ns/1ps
// Shift-register synchroniser; STAGES must be at least 2.
module ab_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ab_width_match.sv
`timescale 1ns/1ps
// Matches a measured low width against each rate's +/-25 % window.
module ab_width_match #(
  parameter int OVS   = 16,
  parameter int RATES = 5,
  parameter int CW    = 9,
  parameter int IW    = 3
) (
  input  logic [CW-1:0] width,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [RATES-1:0] in_win;

  for (genvar k = 0; k < RATES; k++) begin : g_win
    localparam int BC = OVS << k;
    localparam int LO = (3 * BC + 3) / 4;
    localparam int HI = (5 * BC) / 4;
    assign in_win[k] = (width >= CW'(LO)) && (width <= CW'(HI));
  end

  always_comb begin
    hit = |in_win;
    idx = '0;
    for (int k = 0; k < RATES; k++) begin
      if (in_win[k]) idx = IW'(k);
    end
  end

  // R2: windows never overlap, so a width picks at most one rate
  always_comb begin
    if (!$isunknown(width)) begin
      a_r2_one_window: assert ($onehot0(in_win));
    end
  end
endmodule

// File: rtl/ab_tick_div.sv
`timescale 1ns/1ps
// Oversample tick divider: one tick every ratio_m1+1 cycles, cleared by clr.
module ab_tick_div #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] ratio_m1,
  output logic          tick
);
  logic [DW-1:0] div_q, div_d;
  logic          div_en;

  assign tick   = (div_q == ratio_m1);
  assign div_en = 1'b1;

  always_comb begin
    div_d = div_q;
    if (clr)       div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  a_r6_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (div_q <= ratio_m1));
endmodule

// File: rtl/autobaud_rx.sv
`timescale 1ns/1ps
module autobaud_rx
  import ab_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int RATES     = 5,
  parameter int DATA_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_in,
  output logic [DATA_BITS-1:0]     rx_byte,
  output logic                     rx_valid,
  output logic                     baud_ok,
  output logic [$clog2(RATES)-1:0] baud_sel
);
  localparam int IW   = $clog2(RATES);
  localparam int MAXW = (5 * (OVS << (RATES - 1))) / 4;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int OW   = $clog2(OVS);
  localparam int TKW  = $clog2(OVS * (DATA_BITS + 2));
  localparam int DW   = RATES - 1;
  localparam int BW   = TKW - OW;

  logic rst_sn, rxs;

  ab_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn));
  ab_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_sn), .d(rx_in), .q(rxs));

  ab_state_t            state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [TKW-1:0]       tk_q, tk_d;
  logic [DATA_BITS-1:0] sh_q, sh_d, byte_q, byte_d;
  logic                 valid_q, valid_d, lock_q, lock_d, prev_q;
  logic [IW-1:0]        sel_q, sel_d;

  logic          hit, tick, fall, mid;
  logic [IW-1:0] idx;
  logic [DW-1:0] ratio_m1;
  logic [BW-1:0] bidx;

  ab_width_match #(.OVS(OVS), .RATES(RATES), .CW(CW), .IW(IW)) u_match (
    .width(cnt_q), .hit(hit), .idx(idx));

  assign ratio_m1 = DW'((32'd1 << sel_q) - 32'd1);

  ab_tick_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_sn), .clr(state_q != ST_DATA),
    .ratio_m1(ratio_m1), .tick(tick));

  assign fall = prev_q && !rxs;
  assign mid  = (tk_q[OW-1:0] == OW'(OVS / 2 - 1));
  assign bidx = tk_q[TKW-1:OW];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tk_d    = tk_q;
    sh_d    = sh_q;
    byte_d  = byte_q;
    lock_d  = lock_q;
    sel_d   = sel_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          if (lock_q) begin
            state_d = ST_DATA;
            tk_d    = '0;
          end else begin
            state_d = ST_MEAS;
            cnt_d   = CW'(1);
          end
        end
      end
      ST_MEAS: begin
        if (rxs) begin
          if (hit) begin
            lock_d  = 1'b1;
            sel_d   = idx;
            state_d = ST_DATA;
            tk_d    = TKW'(OVS);
          end else begin
            state_d = ST_IDLE;
          end
        end else if (cnt_q == CW'(MAXW)) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (tick) begin
          tk_d = tk_q + 1'b1;
          if (mid) begin
            if (bidx >= BW'(1) && bidx <= BW'(DATA_BITS)) begin
              sh_d = {rxs, sh_q[DATA_BITS-1:1]};
            end else if (bidx == BW'(DATA_BITS + 1)) begin
              state_d = ST_IDLE;
              if (rxs) begin
                valid_d = 1'b1;
                byte_d  = sh_q;
              end
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tk_q    <= '0;
      sh_q    <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
      lock_q  <= 1'b0;
      sel_q   <= '0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tk_q    <= tk_d;
      sh_q    <= sh_d;
      byte_q  <= byte_d;
      valid_q <= valid_d;
      lock_q  <= lock_d;
      sel_q   <= sel_d;
      prev_q  <= rxs;
    end
  end

  assign rx_byte  = byte_q;
  assign rx_valid = valid_q;
  assign baud_ok  = lock_q;
  assign baud_sel = sel_q;

  a_r4_lock_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    lock_q |=> (lock_q && $stable(sel_q)));
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    valid_q |=> !valid_q);
  a_r7_byte_on_valid: assert property (@(posedge clk) disable iff (!rst_sn)
    (byte_q != $past(byte_q)) |-> valid_q);
  a_r5_valid_after_lock: assert property (@(posedge clk) disable iff (!rst_sn)
    valid_q |-> lock_q);
  a_r8_stop_high: assert property (@(posedge clk) disable iff (!rst_sn)
    valid_q |-> $past(rxs));
  a_r3_overlong_abort: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_MEAS && !rxs && cnt_q == CW'(MAXW)) |=>
      (state_q == ST_IDLE && !lock_q));
endmodule

// File: tb/autobaud_rx_test.sv
`timescale 1ns/1ps
module autobaud_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid, baud_ok;
  logic [2:0] baud_sel;

  int n_chk = 0;
  int n_bad = 0;
  int vcnt = 0;
  logic [7:0] vlast = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  autobaud_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .baud_ok(baud_ok), .baud_sel(baud_sel));

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt  = vcnt + 1;
      vlast = rx_byte;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] d, input bit stopv, input int bc);
    for (int i = 0; i < 8; i++) drive(d[i], bc);
    drive(stopv, bc);
    drive(1'b1, 2 * bc);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit stopv, input int bc);
    drive(1'b0, bc);
    send_bits(d, stopv, bc);
  endtask

  task automatic send_cal(input int w, input logic [7:0] d, input int bc);
    drive(1'b0, w);
    send_bits(d, 1'b1, bc);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int exp_rate(input int w);
    for (int k = 0; k < 5; k++) begin
      if (4 * w >= 3 * (16 << k) && 4 * w <= 5 * (16 << k)) return k;
    end
    return -1;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic cal_trial(input int w, input int bc);
    int v0;
    int e;
    do_reset();
    v0 = vcnt;
    send_cal(w, 8'hFF, bc);
    e = exp_rate(w);
    if (e >= 0) begin
      chk("R2 baud_ok", int'(baud_ok), 1);
      chk("R2 baud_sel", int'(baud_sel), e);
      chk("R5 cal count", vcnt - v0, 1);
      chk("R5 cal byte", int'(vlast), 255);
    end else begin
      chk("R3 baud_ok", int'(baud_ok), 0);
      chk("R3 count", vcnt - v0, 0);
    end
  endtask

  initial begin
    logic [7:0] pats [6];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", int'(rx_valid), 0);
    do_reset();
    chk("R1 valid", int'(rx_valid), 0);
    chk("R1 baud_ok", int'(baud_ok), 0);
    chk("R1 baud_sel", int'(baud_sel), 0);
    chk("R1 rx_byte", int'(rx_byte), 0);

    // window sweep: glitch, over-long pulse, and both edges of every window
    cal_trial(1, 16);
    cal_trial(321, 256);
    for (int k = 0; k < 5; k++) begin
      int b;
      b = 16 << k;
      cal_trial((3 * b) / 4 - 1, b);
      cal_trial((3 * b) / 4, b);
      cal_trial(b, b);
      cal_trial((5 * b) / 4, b);
      cal_trial((5 * b) / 4 + 1, b);
    end

    // locked operation per rate
    for (int k = 0; k < 5; k++) begin
      int b;
      int v0;
      logic [7:0] keep;
      b = 16 << k;
      do_reset();
      v0 = vcnt;
      send_cal(b, 8'h55, b);
      chk("R2 sel", int'(baud_sel), k);
      chk("R5 count", vcnt - v0, 1);
      chk("R5 byte", int'(vlast), 8'h55);
      if (k == 0) begin
        for (int d = 0; d < 256; d++) begin
          v0 = vcnt;
          send_frame(8'(d), 1'b1, b);
          chk("R6 r7_ count", vcnt - v0, 1);
          chk("R6 byte", int'(vlast), d);
        end
      end else begin
        for (int i = 0; i < 6; i++) begin
          v0 = vcnt;
          send_frame(pats[i], 1'b1, b);
          chk("R6 r7_ count", vcnt - v0, 1);
          chk("R6 byte", int'(vlast), int'(pats[i]));
        end
      end
      // R8: low stop bit drops the frame
      keep = rx_byte;
      v0 = vcnt;
      send_frame(8'h3C, 1'b0, b);
      chk("R8 count", vcnt - v0, 0);
      chk("R8 rx_byte kept", int'(rx_byte), int'(keep));
      // R4: traffic at another rate leaves the lock alone
      send_frame(8'hFF, 1'b1, (k == 0) ? 32 : b / 2);
      drive(1'b1, 4 * b);
      chk("R4 baud_ok", int'(baud_ok), 1);
      chk("R4 baud_sel", int'(baud_sel), k);
      v0 = vcnt;
      send_frame(8'hC3, 1'b1, b);
      chk("R6 after R4 count", vcnt - v0, 1);
      chk("R6 after R4 byte", int'(vlast), 8'hC3);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule